// File: doc/BRIEF.md
# Interrupt translation register front-end

This block is the software-visible register window, 64 KB wide, of an interrupt translation unit. It holds:

- a control register with an enable bit and a quiescence flag;
- a fixed identification word;
- a type word derived from configuration parameters;
- a command-queue base register, with the queue's write pointer and read pointer;
- base registers for two in-memory tables, one per device and one per collection.

A command-queue walker elsewhere reads the enable, the command base and the write pointer from this block. It reports progress by pulsing a step input, which advances the read pointer by one 32-byte command slot.

The block guards configuration consistency:

- Enabling is refused unless all three base registers are marked valid.
- Base registers are frozen while the unit is enabled.
- Every base write passes through a sanitiser. It removes outer-shareable and inner non-cacheable attributes and limits the outer cache policy.
- The two table bases have their type, entry-size and indirect fields forced.
- From each table base the block derives the number of table entries. The device count is clamped to the device-ID space.

Accesses use a request/response bus with a one-cycle registered response. The access size is encoded 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An access of the wrong width to a defined register returns a fault, and the access has no effect.

Top module: `its_xlate_regfe`

## Requirements
- R1: Every request gets its response one clock later. Control (offset 0x000) reads bit 0 = enable and bit 31 = quiescent. Quiescent is 1 only when write pointer equals read pointer and walker_busy_i is low in the cycle of the request. After reset the read returns 0x80000000.
- R2: Writing control bit 0 = 1 sets the enable only if bit 63 (valid) is set in the command base (0x080), the device base (0x100) and the collection base (0x108). Otherwise the write is ignored. Writing bit 0 = 0 always disables.
- R3: While enabled, writes to any of the three base registers are ignored.
- R4: An accepted command base write clears the read pointer. While enabled, a cycle with rd_step_i high and pointers unequal advances the read pointer (0x090) by 32. It wraps to 0 on reaching (cmd_base[7:0]+1)×4096. Steps while disabled are ignored.
- R5: The write pointer (0x088) stores only bits [19:5] of the written value. Writes to the read pointer are ignored.
- R6: Offset 0x004 reads 0x5800034C. The type register (0x008) reads with:
  - bit 0 = 1;
  - [7:4] = ITT_ENTRY_BYTES−1;
  - [12:8] = EVID_BITS−1;
  - [17:13] = DEVID_BITS−1.

  Writes to both are ignored.
- R7: A table base's page field [9:8] decodes 0→4 KB, 1→16 KB, 2 and 3→64 KB. Its entry count is page × ([7:0]+1) / entry bytes, with 8 bytes for the device table and 2 bytes for the collection table. The device count is clamped to 2^DEVID_BITS. A count is 0 when bit 63 is clear.
- R8: On every base write, shareability [11:10] = 2 becomes 1 and inner cache [61:59] of 0 or 1 becomes 3. Outer cache [55:53] other than 0 or 1 becomes 1.
- R9: Table base writes force bit 62 to 0 and entry size [52:48] to 7 (device) or 1 (collection). They force type [58:56] to 1 (device) or 4 (collection).
- R10: Offsets 0x110–0x13F and all offsets without a register read as zero and ignore writes. Unassigned offsets raise no fault at any width.
- R11: The response fault flag is set, the read data is zero, and nothing is written in two cases. The first is a non-4-byte or unaligned access to 0x000 or 0x004. The second is an access to a 64-bit register (0x008, 0x080–0x097, 0x100–0x13F) that is neither 8-byte aligned at size 3 nor 4-byte aligned at size 2.
- R12: A 4-byte access to a 64-bit register addresses the low half when address bit 2 is 0 and the high half when it is 1. Reads return the half in bits [31:0]. Writes merge into the other half unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Byte offset in the window |
| req_size_i | input | 2 | Access size code |
| req_wdata_i | input | 64 | Write data, low-aligned |
| rsp_valid_o | output | 1 | Response, one cycle after request |
| rsp_rdata_o | output | 64 | Read data |
| rsp_fault_o | output | 1 | Width/alignment violation |
| walker_busy_i | input | 1 | Walker currently holds the queue |
| rd_step_i | input | 1 | Walker consumed one command slot |
| enable_o | output | 1 | Unit enabled |
| cmd_base_o | output | 64 | Command queue base register |
| wr_ptr_o | output | 20 | Write pointer byte offset |
| rd_ptr_o | output | 20 | Read pointer byte offset |
| dev_entries_o | output | 32 | Usable device table entries |
| coll_entries_o | output | 32 | Usable collection table entries |

## Verification
Some properties are checked on every cycle by assertions:

- enable never stands without all three valid bits;
- the base registers do not move while enabled;
- no stored base holds outer-shareable or the indirect bit;
- the device count never exceeds its clamp;
- the read pointer stays inside the queue and is zero after a base write;
- a fault always comes with zero data.

Only the bench scenarios can show the exact sanitised field values, entry counts and half-word merges. They also show refused enables, wraparound and quiescence as observed through register reads. The bench sweeps every shareability and cacheability combination and every page-size encoding in a small configuration.

// File: rtl/its_fe_pkg.sv
package its_fe_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_CTLR, K_IDENT, K_TYPE, K_CMDB, K_WPTR, K_RPTR,
    K_DEVB, K_COLB, K_SPARE
  } reg_kind_e;

  localparam logic [31:0] IDENT_WORD   = 32'h5800_034C;
  localparam int          DEV_ENT_LOG2 = 3;  // 8-byte device entries
  localparam int          COL_ENT_LOG2 = 1;  // 2-byte collection entries

  function automatic reg_kind_e decode_offset(input logic [15:0] off);
    reg_kind_e k;
    k = K_NONE;
    if (off[15:3] == 13'h0)                            k = off[2] ? K_IDENT : K_CTLR;
    else if (off[15:3] == 13'h1)                       k = K_TYPE;
    else if (off[15:3] == 13'h10)                      k = K_CMDB;
    else if (off[15:3] == 13'h11)                      k = K_WPTR;
    else if (off[15:3] == 13'h12)                      k = K_RPTR;
    else if (off[15:3] == 13'h20)                      k = K_DEVB;
    else if (off[15:3] == 13'h21)                      k = K_COLB;
    else if (off[15:3] >= 13'h22 && off[15:3] <= 13'h27) k = K_SPARE;
    return k;
  endfunction

  function automatic logic [63:0] merge_half(input logic [63:0] cur,
                                             input logic [63:0] wd,
                                             input logic full, input logic hi);
    if (full) return wd;
    return hi ? {wd[31:0], cur[31:0]} : {cur[63:32], wd[31:0]};
  endfunction

  function automatic logic [31:0] table_entries(input logic [63:0] base,
                                                input int entry_log2);
    logic [31:0] page;
    case (base[9:8])
      2'd0:    page = 32'd4096;
      2'd1:    page = 32'd16384;
      default: page = 32'd65536;
    endcase
    return (page * ({24'd0, base[7:0]} + 32'd1)) >> entry_log2;
  endfunction

  function automatic logic [20:0] queue_bytes(input logic [7:0] pages);
    return ({13'd0, pages} + 21'd1) << 12;
  endfunction

endpackage

// File: rtl/its_base_sanitizer.sv
module its_base_sanitizer #(
  parameter int KIND = 0  // 0 command base, 1 device table, 2 collection table
) (
  input  logic [63:0] raw_i,
  output logic [63:0] clean_o
);
  logic [63:0] attr;

  always_comb begin
    attr = raw_i;
    if (attr[11:10] == 2'd2)  attr[11:10] = 2'd1;
    if (attr[61:59] <= 3'd1)  attr[61:59] = 3'd3;
    if (attr[55:53] > 3'd1)   attr[55:53] = 3'd1;
  end

  generate
    if (KIND == 0) begin : g_cmd
      assign clean_o = attr;
    end else begin : g_table
      localparam logic [2:0] TYPE_CODE  = (KIND == 1) ? 3'd1 : 3'd4;
      localparam logic [4:0] ENTRY_CODE = (KIND == 1) ? 5'd7 : 5'd1;
      assign clean_o = {attr[63], 1'b0, attr[61:59], TYPE_CODE, attr[55:53],
                        ENTRY_CODE, attr[47:0]};
    end
  endgenerate

endmodule

// File: rtl/its_cmd_queue_ptrs.sv
module its_cmd_queue_ptrs
  import its_fe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable_i,
  input  logic        wptr_we_i,
  input  logic [14:0] wptr_slot_i,
  input  logic        rptr_clear_i,
  input  logic        step_i,
  input  logic [7:0]  buf_pages_i,
  output logic [19:0] wptr_o,
  output logic [19:0] rptr_o
);
  logic [19:0] wptr_q, rptr_q;
  logic [20:0] rptr_next;
  logic        step_ev;

  assign step_ev   = step_i && enable_i && (rptr_q != wptr_q);
  assign rptr_next = {1'b0, rptr_q} + 21'd32;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (wptr_we_i) wptr_q <= {wptr_slot_i, 5'd0};
      if (rptr_clear_i)
        rptr_q <= '0;
      else if (step_ev)
        rptr_q <= (rptr_next >= queue_bytes(buf_pages_i)) ? 20'd0 : rptr_next[19:0];
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;

  AST_RPTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    rptr_clear_i |=> (rptr_o == 20'd0)); // R4
  AST_RPTR_IN_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, rptr_o} < queue_bytes(buf_pages_i)); // R4

endmodule

// File: rtl/its_xlate_regfe.sv
module its_xlate_regfe
  import its_fe_pkg::*;
#(
  parameter int DEVID_BITS      = 16,
  parameter int EVID_BITS       = 16,
  parameter int ITT_ENTRY_BYTES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid_i,
  input  logic        req_write_i,
  input  logic [15:0] req_addr_i,
  input  logic [1:0]  req_size_i,
  input  logic [63:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [63:0] rsp_rdata_o,
  output logic        rsp_fault_o,
  input  logic        walker_busy_i,
  input  logic        rd_step_i,
  output logic        enable_o,
  output logic [63:0] cmd_base_o,
  output logic [19:0] wr_ptr_o,
  output logic [19:0] rd_ptr_o,
  output logic [31:0] dev_entries_o,
  output logic [31:0] coll_entries_o
);
  localparam logic [63:0] TYPE_WORD = 64'd1
    | (64'(ITT_ENTRY_BYTES - 1) << 4)
    | (64'(EVID_BITS - 1) << 8)
    | (64'(DEVID_BITS - 1) << 13);
  localparam logic [32:0] DEV_CAP = 33'd1 << DEVID_BITS;

  reg_kind_e   kind;
  logic        is_w, is_dw, hit32, hit64, ok32, ok64, hi;
  logic        bad_width, acc_ok, wr_ok;
  logic [63:0] cur64, merged, rd_val;
  logic [63:0] san [3];
  logic [63:0] cmd_q, dev_q, coll_q;
  logic        enable_q, all_valid;
  logic        cmdb_wr_ev, devb_wr_ev, colb_wr_ev, wptr_wr_ev, ctlr_wr_ev;
  logic [19:0] wptr, rptr;
  logic [32:0] dev_raw;

  // ---------------- decode and width policing ----------------
  assign kind  = decode_offset(req_addr_i);
  assign is_w  = (req_size_i == 2'd2);
  assign is_dw = (req_size_i == 2'd3);
  assign hi    = req_addr_i[2];
  assign hit32 = (kind == K_CTLR) || (kind == K_IDENT);
  assign hit64 = (kind != K_NONE) && !hit32;
  assign ok32  = is_w && (req_addr_i[1:0] == 2'b00);
  assign ok64  = (is_dw && (req_addr_i[2:0] == 3'b000)) || ok32;

  assign bad_width = req_valid_i && ((hit32 && !ok32) || (hit64 && !ok64));
  assign acc_ok    = req_valid_i && !bad_width;
  assign wr_ok     = acc_ok && req_write_i;

  // ---------------- current value and merge ----------------
  always_comb begin
    case (kind)
      K_TYPE:  cur64 = TYPE_WORD;
      K_CMDB:  cur64 = cmd_q;
      K_WPTR:  cur64 = {44'd0, wptr};
      K_RPTR:  cur64 = {44'd0, rptr};
      K_DEVB:  cur64 = dev_q;
      K_COLB:  cur64 = coll_q;
      default: cur64 = 64'd0;
    endcase
  end

  assign merged = merge_half(cur64, req_wdata_i, is_dw, hi);

  generate
    for (genvar k = 0; k < 3; k++) begin : g_san
      its_base_sanitizer #(.KIND(k)) u_san (.raw_i(merged), .clean_o(san[k]));
    end
  endgenerate

  // ---------------- write events ----------------
  assign all_valid  = cmd_q[63] && dev_q[63] && coll_q[63];
  assign cmdb_wr_ev = wr_ok && (kind == K_CMDB) && !enable_q;
  assign devb_wr_ev = wr_ok && (kind == K_DEVB) && !enable_q;
  assign colb_wr_ev = wr_ok && (kind == K_COLB) && !enable_q;
  assign wptr_wr_ev = wr_ok && (kind == K_WPTR);
  assign ctlr_wr_ev = wr_ok && (kind == K_CTLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      dev_q    <= '0;
      coll_q   <= '0;
      enable_q <= 1'b0;
    end else begin
      if (cmdb_wr_ev) cmd_q  <= san[0];
      if (devb_wr_ev) dev_q  <= san[1];
      if (colb_wr_ev) coll_q <= san[2];
      if (ctlr_wr_ev) begin
        if (!req_wdata_i[0])   enable_q <= 1'b0;
        else if (!enable_q)    enable_q <= all_valid;
      end
    end
  end

  its_cmd_queue_ptrs u_ptrs (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_q),
    .wptr_we_i    (wptr_wr_ev),
    .wptr_slot_i  (merged[19:5]),
    .rptr_clear_i (cmdb_wr_ev),
    .step_i       (rd_step_i),
    .buf_pages_i  (cmd_q[7:0]),
    .wptr_o       (wptr),
    .rptr_o       (rptr)
  );

  // ---------------- read path and response ----------------
  always_comb begin
    case (kind)
      K_CTLR:  rd_val = {32'd0, (wptr == rptr) && !walker_busy_i, 30'd0, enable_q};
      K_IDENT: rd_val = {32'd0, IDENT_WORD};
      default: rd_val = is_dw ? cur64 : (hi ? {32'd0, cur64[63:32]} : {32'd0, cur64[31:0]});
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_fault_o <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= bad_width;
      rsp_rdata_o <= (acc_ok && !req_write_i) ? rd_val : 64'd0;
    end
  end

  // ---------------- derived outputs ----------------
  assign dev_raw = {1'b0, table_entries(dev_q, DEV_ENT_LOG2)};
  assign dev_entries_o  = !dev_q[63] ? 32'd0 : (dev_raw > DEV_CAP ? DEV_CAP[31:0] : dev_raw[31:0]);
  assign coll_entries_o = !coll_q[63] ? 32'd0 : table_entries(coll_q, COL_ENT_LOG2);
  assign enable_o   = enable_q;
  assign cmd_base_o = cmd_q;
  assign wr_ptr_o   = wptr;
  assign rd_ptr_o   = rptr;

  // ---------------- assertions ----------------
  AST_ENABLE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    enable_o |-> (cmd_q[63] && dev_q[63] && coll_q[63])); // R2
  AST_BASES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_o && $past(enable_o)) |-> ($stable(cmd_q) && $stable(dev_q) && $stable(coll_q))); // R3
  AST_NO_OUTER_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[11:10] != 2'd2) && (dev_q[11:10] != 2'd2) && (coll_q[11:10] != 2'd2)); // R8
  AST_NO_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_q[62] && !coll_q[62]); // R9
  AST_DEV_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, dev_entries_o} <= DEV_CAP); // R7
  AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_o |-> (rsp_valid_o && rsp_rdata_o == 64'd0)); // R11

endmodule

// File: tb/its_xlate_regfe_bench.sv
module its_xlate_regfe_bench;
  localparam int DEVB = 10, EVB = 8, ITTB = 8;
  localparam logic [63:0] VALID = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, walker_busy = 0, rd_step = 0;
  logic [15:0] req_addr = 0;
  logic [1:0]  req_size = 0;
  logic [63:0] req_wdata = 0;
  logic        rsp_valid, rsp_fault, enable;
  logic [63:0] rsp_rdata, cmd_base;
  logic [19:0] wr_ptr, rd_ptr;
  logic [31:0] dev_entries, coll_entries;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  its_xlate_regfe #(.DEVID_BITS(DEVB), .EVID_BITS(EVB), .ITT_ENTRY_BYTES(ITTB)) u_its_xlate_regfe (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_fault_o(rsp_fault),
    .walker_busy_i(walker_busy), .rd_step_i(rd_step), .enable_o(enable),
    .cmd_base_o(cmd_base), .wr_ptr_o(wr_ptr), .rd_ptr_o(rd_ptr),
    .dev_entries_o(dev_entries), .coll_entries_o(coll_entries));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one access; called at a falling edge, returns at the next falling edge
  task automatic acc(input logic w, input logic [15:0] a, input logic [1:0] sz,
                     input logic [63:0] d, output logic [63:0] rd, output logic f);
    req_valid = 1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd = rsp_rdata; f = rsp_fault;
    if (!rsp_valid) check("R1 response valid", 0, 1);
  endtask

  task automatic steps(input int n);
    rd_step = 1;
    repeat (n) @(negedge clk);
    rd_step = 0;
  endtask

  function automatic logic [63:0] put(input logic [63:0] v, input int lsb,
                                      input int w, input logic [63:0] f);
    logic [63:0] m = ((64'd1 << w) - 64'd1) << lsb;
    return (v & ~m) | ((f << lsb) & m);
  endfunction

  function automatic logic [63:0] exp_clean(input logic [63:0] v, input int kind);
    logic [63:0] r = v;
    if (((r >> 10) & 64'h3) == 64'h2) r = put(r, 10, 2, 1);
    if (((r >> 59) & 64'h7) < 64'h2)  r = put(r, 59, 3, 3);
    if (((r >> 53) & 64'h7) > 64'h1)  r = put(r, 53, 3, 1);
    if (kind == 1) begin r = put(r, 62, 1, 0); r = put(r, 56, 3, 1); r = put(r, 48, 5, 7); end
    if (kind == 2) begin r = put(r, 62, 1, 0); r = put(r, 56, 3, 4); r = put(r, 48, 5, 1); end
    return r;
  endfunction

  function automatic longint exp_count(input logic [63:0] v, input int ebytes, input bit clamp);
    longint pg, n;
    if (!v[63]) return 0;
    pg = (v[9:8] == 0) ? 4096 : (v[9:8] == 1) ? 16384 : 65536;
    n = pg * (longint'(v[7:0]) + 1) / ebytes;
    if (clamp && n > (longint'(1) << DEVB)) n = longint'(1) << DEVB;
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] r, e, v;
    logic f;
    int pgs[4] = '{0, 1, 3, 255};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    acc(0, 16'h0000, 2, 0, r, f); check("R1 ctlr after reset", r, 64'h8000_0000);
    check("R1 enable after reset", enable, 0);
    // R6 identification and type
    acc(0, 16'h0004, 2, 0, r, f); check("R6 ident", r, 64'h5800_034C);
    e = 64'd1 | (64'(ITTB-1) << 4) | (64'(EVB-1) << 8) | (64'(DEVB-1) << 13);
    acc(0, 16'h0008, 3, 0, r, f); check("R6 type dword", r, e);
    acc(1, 16'h0008, 3, '1, r, f);
    acc(0, 16'h0008, 2, 0, r, f); check("R6 R12 type low word after write", r, e);
    acc(0, 16'h000C, 2, 0, r, f); check("R12 type high word", r, 0);
    // R2 enable refused without valid bases
    acc(1, 16'h0000, 2, 1, r, f);
    acc(0, 16'h0000, 2, 0, r, f); check("R2 enable refused", r, 64'h8000_0000);
    // R11 width faults
    acc(0, 16'h0000, 3, 0, r, f); check("R11 ctlr dword fault", f, 1);
    acc(0, 16'h0004, 1, 0, r, f); check("R11 ident half fault", f, 1);
    acc(1, 16'h0080, 1, VALID | 64'h3, r, f); check("R11 cmdbase half fault", f, 1);
    check("R11 faulting write dropped", cmd_base, 0);
    acc(0, 16'h0084, 3, 0, r, f); check("R11 misaligned dword fault", f, 1);
    acc(0, 16'h0128, 0, 0, r, f); check("R11 spare base byte fault", f, 1);
    acc(0, 16'h0001, 2, 0, r, f); check("R11 unaligned ctlr fault", f, 1);
    // R10 read-as-zero / write-ignored
    acc(0, 16'h0040, 0, 0, r, f); check("R10 reserved byte no fault", f, 0);
    acc(1, 16'h0118, 3, '1, r, f);
    acc(0, 16'h0118, 3, 0, r, f); check("R10 spare base reads zero", r, 0);
    acc(1, 16'h0200, 2, '1, r, f);
    acc(0, 16'h0200, 2, 0, r, f); check("R10 reserved reads zero", r, 0);
    acc(1, 16'hC000, 3, '1, r, f);
    acc(0, 16'hC000, 3, 0, r, f); check("R10 impl range reads zero", {63'd0, f} | r, 0);
    // R5 pointer masks
    acc(1, 16'h0088, 3, '1, r, f);
    acc(0, 16'h0088, 3, 0, r, f); check("R5 wptr mask", r, 64'hFFFE0);
    acc(1, 16'h008C, 2, 64'hFFFF_FFFF, r, f);
    acc(0, 16'h0088, 3, 0, r, f); check("R5 R12 wptr high half dropped", r, 64'hFFFE0);
    acc(0, 16'h0000, 2, 0, r, f); check("R1 not quiescent", r, 0);
    acc(1, 16'h0090, 3, 64'h40, r, f);
    acc(0, 16'h0090, 3, 0, r, f); check("R5 rptr write ignored", r, 0);
    acc(1, 16'h0088, 3, 0, r, f);
    // R7 R9 device table sweep
    for (int ps = 0; ps < 4; ps++)
      for (int i = 0; i < 4; i++) begin
        v = VALID | 64'h0000_0012_3400_0000 | (64'(ps) << 8) | 64'(pgs[i]) | (64'h7 << 56) | (64'h1 << 62);
        acc(1, 16'h0100, 3, v, r, f);
        acc(0, 16'h0100, 3, 0, r, f); check("R9 device base fields", r, exp_clean(v, 1));
        check("R7 device entries", dev_entries, 64'(exp_count(v, 8, 1)));
      end
    acc(1, 16'h0100, 3, 64'h303, r, f); check("R7 device invalid count", dev_entries, 0);
    // R8 R9 collection sweep over all attribute combinations
    for (int sh = 0; sh < 4; sh++)
      for (int ic = 0; ic < 8; ic++)
        for (int oc = 0; oc < 8; oc++) begin
          v = VALID | (64'(ic) << 59) | (64'(oc) << 53) | (64'(sh) << 10) |
              64'h0000_0045_6000_0000 | (64'(oc & 3) << 8) | 64'(ic * 9);
          acc(1, 16'h0108, 3, v, r, f);
          acc(0, 16'h0108, 3, 0, r, f); check("R8 collection attributes", r, exp_clean(v, 2));
          check("R7 collection entries", coll_entries, 64'(exp_count(v, 2, 0)));
        end
    // R12 R8 command base by halves
    e = 0;
    acc(1, 16'h0080, 2, 64'h0001_2800, r, f); e = exp_clean({e[63:32], 32'h0001_2800}, 0);
    acc(1, 16'h0084, 2, 64'h8000_0000, r, f); e = exp_clean({32'h8000_0000, e[31:0]}, 0);
    acc(0, 16'h0080, 3, 0, r, f); check("R12 R8 command base merged", r, e);
    acc(0, 16'h0084, 2, 0, r, f); check("R12 high half read", r, {32'd0, e[63:32]});
    check("R8 command base output", cmd_base, e);
    // enable with all valid
    acc(1, 16'h0100, 3, VALID | 64'h1, r, f);
    acc(1, 16'h0000, 2, 1, r, f);
    acc(0, 16'h0000, 2, 0, r, f); check("R2 enable accepted", r, 64'h8000_0001);
    check("R2 enable output", enable, 1);
    // R3 frozen bases
    acc(1, 16'h0100, 3, VALID | 64'h2, r, f);
    acc(0, 16'h0100, 3, 0, r, f); check("R3 device base frozen", r, exp_clean(VALID | 64'h1, 1));
    acc(1, 16'h0080, 3, 64'h0, r, f); check("R3 command base frozen", cmd_base, e);
    // R4 R1 stepping and quiescence
    acc(1, 16'h0088, 3, 64'h40, r, f);
    acc(0, 16'h0000, 2, 0, r, f); check("R1 busy queue", r, 64'h1);
    steps(1); check("R4 one step", rd_ptr, 20'h20);
    steps(3); check("R4 stops at wptr", rd_ptr, 20'h40);
    acc(0, 16'h0000, 2, 0, r, f); check("R1 quiescent", r, 64'h8000_0001);
    walker_busy = 1;
    acc(0, 16'h0000, 2, 0, r, f); check("R1 walker busy", r, 64'h1);
    walker_busy = 0;
    acc(1, 16'h0088, 3, 64'hFE0, r, f);
    steps(200); check("R4 reaches end slot", rd_ptr, 20'hFE0);
    acc(1, 16'h0088, 3, 64'h20, r, f);
    steps(1); check("R4 wrap to zero", rd_ptr, 0);
    steps(1); check("R4 after wrap", rd_ptr, 20'h20);
    // disable, steps ignored, base write clears read pointer
    acc(1, 16'h0000, 2, 0, r, f);
    acc(0, 16'h0000, 2, 0, r, f); check("R2 disable", r, 64'h8000_0000);
    acc(1, 16'h0088, 3, 64'h60, r, f);
    steps(3); check("R4 step ignored disabled", rd_ptr, 20'h20);
    acc(1, 16'h0080, 3, VALID | 64'h1, r, f);
    acc(0, 16'h0090, 3, 0, r, f); check("R4 base write clears rptr", r, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule